// File: doc/BRIEF.md
# Split/Combined Timer-Counter with Capture

This block is a timer/counter built from two 8-bit halves, low and high. A 2-bit mode input chooses how the halves are used. They can be two separate prescaled timers. The low half can be a prescaled timer while the high half counts external events. The halves can also join into one 16-bit prescaled timer or one 16-bit event counter. A shared programmable prescaler turns the per-cycle enable `tick_en` into timer ticks. Events arrive on one shared input pin. Each half has its own capture strobe, which copies the live count into an output capture register without disturbing the count.

The prescaler divide value and the two match values are loaded through write strobes that share a data bus. When a count equals its match value on a counting step, the count returns to zero and a one-cycle interrupt pulse is raised. All pins are plain control and status signals, because the block has no streaming data path and therefore no valid/ready handshake. The asynchronous pins (event and both strobes) pass through a two-flop synchronizer, and only their rising edges act.

Top module: `split_capture_timer`

## Requirements
- R1: After reset:
  - both counts, both capture registers and both interrupt outputs are zero;
  - the prescale value is zero, so there is one tick per enabled cycle;
  - both match values are all ones.
- R2: The prescaler delivers one tick every (P+1) cycles in which `tick_en` is high, where P is the programmed prescale value. Cycles with `tick_en` low neither advance nor reset it.
- R3: In mode 0 and mode 1 the low half counts prescaler ticks against match value ML.
  - A tick taken while the low count equals ML returns the count to 0 and pulses `irq_lo` for one cycle.
  - Otherwise the tick increments the count.
- R4: In mode 0 the high half is a second prescaled timer with its own match value MH, and it pulses `irq_hi` in the same way.
- R5: In mode 1 the high half counts synchronized rising edges of `evt_in` against MH, whether `tick_en` is high or low.
- R6: In mode 2 the halves form one 16-bit timer, high half as bits 15:8, counting prescaler ticks.
  - The 16-bit match value is {MH,ML}.
  - Only `irq_hi` is raised.
  - `irq_lo` stays low.
- R7: In mode 3 the halves form one 16-bit counter of synchronized `evt_in` rising edges. It matches against {MH,ML} and raises only `irq_hi`. Prescaler ticks do not change it.
- R8: In modes 0 and 1, a rising edge on `cap_lo_in` copies the low count into `cap_lo`, and a rising edge on `cap_hi_in` copies the high count into `cap_hi`. The copy happens three clock edges after the pin is first sampled high.
- R9: In modes 2 and 3, a rising edge on `cap_hi_in` copies the whole 16-bit count into {`cap_hi`,`cap_lo`}. A rising edge on `cap_lo_in` has no effect.
- R10: A capture does not stop, clear or otherwise change the running count.
- R11: Any change of `mode` clears both halves to zero and restarts the prescaler from its programmed value.
- R12: The event and capture inputs act on their rising edge only. A level held high for many cycles counts once.
- R13: The write strobes load `wr_data`. `wr_presc` loads P and at once restarts the prescaler from the new value. `wr_match_lo` loads ML and `wr_match_hi` loads MH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable that advances the prescaler |
| mode | input | 2 | 0 dual timer, 1 timer plus event counter, 2 16-bit timer, 3 16-bit event counter |
| evt_in | input | 1 | Asynchronous external event input |
| cap_lo_in | input | 1 | Asynchronous low-half capture strobe |
| cap_hi_in | input | 1 | Asynchronous high-half capture strobe |
| wr_presc | input | 1 | Load prescale value from wr_data |
| wr_match_lo | input | 1 | Load low match value from wr_data |
| wr_match_hi | input | 1 | Load high match value from wr_data |
| wr_data | input | W | Write data |
| cap_lo | output | W | Low capture register |
| cap_hi | output | W | High capture register |
| irq_lo | output | 1 | Low-half match pulse |
| irq_hi | output | 1 | High-half or 16-bit match pulse |

## Verification
The sweep crosses the prescale and match values in each mode and predicts ticks, counts and interrupt totals by integer division and remainder. A prescaler that divided by P instead of P+1, or a counter that cleared one step early, would show wrong residues in the captured values.

Runs are split by idle gaps, with a capture in between. This exposes a prescaler that restarts when `tick_en` drops, and a capture that disturbs the count. A prescale rewrite made in mid-count checks that the prescaler restarts at once.

The 16-bit cases use match values above 255, so a broken carry from low half to high half shows up. A low-half strobe issued in those modes must leave the capture outputs at zero. A long event pulse and a mode switch check that events count on edges only and that a mode change clears both halves.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT_TMR = 2'd0,
    MODE_TMR_EVT   = 2'd1,
    MODE_WIDE_TMR  = 2'd2,
    MODE_WIDE_EVT  = 2'd3
  } sct_mode_e;
endpackage

// File: rtl/sct_edge_sync.sv
module sct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sct_prescaler.sv
module sct_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         restart,
  input  logic [W-1:0] reload_val,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = tick_en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= reload_val;
    else if (tick_en)  cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
  end
endmodule

// File: rtl/sct_counter_pair.sv
module sct_counter_pair #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wide,
  input  logic         clear,
  input  logic         inc_lo,
  input  logic         inc_hi,
  input  logic [W-1:0] match_lo,
  input  logic [W-1:0] match_hi,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         hit_lo,
  output logic         hit_hi
);
  localparam int WW = 2 * W;
  logic [WW-1:0] full, full_match;

  assign full       = {cnt_hi, cnt_lo};
  assign full_match = {match_hi, match_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      hit_lo <= 1'b0;
      hit_hi <= 1'b0;
    end else begin
      hit_lo <= 1'b0;
      hit_hi <= 1'b0;
      if (clear) begin
        cnt_lo <= '0;
        cnt_hi <= '0;
      end else if (wide) begin
        if (inc_lo) begin
          if (full == full_match) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            hit_hi <= 1'b1;
          end else begin
            {cnt_hi, cnt_lo} <= full + WW'(1);
          end
        end
      end else begin
        if (inc_lo) begin
          if (cnt_lo == match_lo) begin
            cnt_lo <= '0;
            hit_lo <= 1'b1;
          end else begin
            cnt_lo <= cnt_lo + 1'b1;
          end
        end
        if (inc_hi) begin
          if (cnt_hi == match_hi) begin
            cnt_hi <= '0;
            hit_hi <= 1'b1;
          end else begin
            cnt_hi <= cnt_hi + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sct_capture.sv
module sct_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wide,
  input  logic         strobe_lo,
  input  logic         strobe_hi,
  input  logic [W-1:0] cnt_lo,
  input  logic [W-1:0] cnt_hi,
  output logic [W-1:0] cap_lo,
  output logic [W-1:0] cap_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_lo <= '0;
      cap_hi <= '0;
    end else begin
      if (strobe_hi) begin
        cap_hi <= cnt_hi;
        if (wide) cap_lo <= cnt_lo;
      end
      if (strobe_lo && !wide) cap_lo <= cnt_lo;
    end
  end
endmodule

// File: rtl/split_capture_timer.sv
module split_capture_timer
  import sct_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [1:0]   mode,
  input  logic         evt_in,
  input  logic         cap_lo_in,
  input  logic         cap_hi_in,
  input  logic         wr_presc,
  input  logic         wr_match_lo,
  input  logic         wr_match_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cap_lo,
  output logic [W-1:0] cap_hi,
  output logic         irq_lo,
  output logic         irq_hi
);
  localparam int N_SYNC  = 3;
  localparam int IDX_EVT = 0;
  localparam int IDX_CLO = 1;
  localparam int IDX_CHI = 2;

  logic [N_SYNC-1:0] raw_in, rise;
  assign raw_in = {cap_hi_in, cap_lo_in, evt_in};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    sct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .rise (rise[g])
    );
  end

  logic [W-1:0] presc_q, match_lo_q, match_hi_q;
  sct_mode_e    mode_e, mode_q;

  assign mode_e = sct_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q    <= '0;
      match_lo_q <= '1;
      match_hi_q <= '1;
      mode_q     <= MODE_SPLIT_TMR;
    end else begin
      if (wr_presc)    presc_q    <= wr_data;
      if (wr_match_lo) match_lo_q <= wr_data;
      if (wr_match_hi) match_hi_q <= wr_data;
      mode_q <= mode_e;
    end
  end

  logic mode_chg, wide, pre_tick, inc_lo, inc_hi;
  assign mode_chg = (mode_e != mode_q);
  assign wide     = (mode_e == MODE_WIDE_TMR) || (mode_e == MODE_WIDE_EVT);

  sct_prescaler #(.W(W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .restart   (wr_presc || mode_chg),
    .reload_val(wr_presc ? wr_data : presc_q),
    .tick      (pre_tick)
  );

  assign inc_lo = (mode_e == MODE_WIDE_EVT) ? rise[IDX_EVT] : pre_tick;
  assign inc_hi = (mode_e == MODE_TMR_EVT)  ? rise[IDX_EVT] : pre_tick;

  logic [W-1:0] cnt_lo, cnt_hi;

  sct_counter_pair #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide    (wide),
    .clear   (mode_chg),
    .inc_lo  (inc_lo),
    .inc_hi  (inc_hi),
    .match_lo(match_lo_q),
    .match_hi(match_hi_q),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .hit_lo  (irq_lo),
    .hit_hi  (irq_hi)
  );

  sct_capture #(.W(W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (wide),
    .strobe_lo(rise[IDX_CLO]),
    .strobe_hi(rise[IDX_CHI]),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi)
  );
endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         evt_in,
  input logic         cap_lo_in,
  input logic         cap_hi_in,
  input logic [W-1:0] cap_lo,
  input logic [W-1:0] cap_hi,
  input logic         irq_lo,
  input logic         irq_hi,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi
);
  // R6
  wide_no_irq_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode[1]) |-> !irq_lo);

  // R7
  wide_evt_irq_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi && $past(mode) == 2'd3) |-> $past(evt_in, 3));

  // R8
  cap_lo_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_lo) |-> ($past(cap_lo_in, 3) || $past(cap_hi_in, 3)));

  // R9
  cap_hi_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_hi) |-> $past(cap_hi_in, 3));

  // R11
  mode_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |=> (cnt_lo == '0 && cnt_hi == '0));
endmodule

bind split_capture_timer sct_checker #(.W(W)) u_sct_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .evt_in   (evt_in),
  .cap_lo_in(cap_lo_in),
  .cap_hi_in(cap_hi_in),
  .cap_lo   (cap_lo),
  .cap_hi   (cap_hi),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi)
);

// File: tb/split_capture_timer_tb_top.sv
module split_capture_timer_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, evt_in = 1'b0;
  logic cap_lo_in = 1'b0, cap_hi_in = 1'b0;
  logic wr_presc = 1'b0, wr_match_lo = 1'b0, wr_match_hi = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cap_lo, cap_hi;
  logic         irq_lo, irq_hi;

  split_capture_timer #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
    .evt_in(evt_in), .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
    .wr_presc(wr_presc), .wr_match_lo(wr_match_lo), .wr_match_hi(wr_match_hi),
    .wr_data(wr_data), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, irq_lo_n = 0, irq_hi_n = 0, cyc = 0;

  always @(negedge clk) if (rst_n) begin
    irq_lo_n += int'(irq_lo);
    irq_hi_n += int'(irq_hi);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; mode = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(int sel, int v);
    wr_data = W'(v);
    wr_presc = (sel == 0); wr_match_lo = (sel == 1); wr_match_hi = (sel == 2);
    @(negedge clk);
    wr_presc = 1'b0; wr_match_lo = 1'b0; wr_match_hi = 1'b0;
  endtask

  task automatic run(int k);
    tick_en = 1'b1;
    repeat (k) @(negedge clk);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cap(bit hi);
    if (hi) cap_hi_in = 1'b1; else cap_lo_in = 1'b1;
    repeat (2) @(negedge clk);
    cap_hi_in = 1'b0; cap_lo_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic evts(int n);
    for (int i = 0; i < n; i++) begin
      evt_in = 1'b1; repeat (2) @(negedge clk);
      evt_in = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic long_evt();
    evt_in = 1'b1; repeat (20) @(negedge clk);
    evt_in = 1'b0; repeat (4) @(negedge clk);
  endtask

  initial begin
    int b_lo, b_hi, t, m16, k;
    int p_set[3] = '{0, 1, 3};
    int ml_set[3] = '{0, 2, 5};

    // R1 reset state
    do_reset(2'd0);
    chk("R1 cap_lo after reset", int'(cap_lo), 0);
    chk("R1 cap_hi after reset", int'(cap_hi), 0);
    chk("R1 irq_lo after reset", int'(irq_lo), 0);
    chk("R1 irq_hi after reset", int'(irq_hi), 0);

    // R1 default match all ones, default prescale 1
    b_lo = irq_lo_n; b_hi = irq_hi_n;
    run(300);
    cap(1'b0); cap(1'b1);
    chk("R1 default low count", int'(cap_lo), 300 % 256);
    chk("R1 default high count", int'(cap_hi), 300 % 256);
    chk("R1 default irq_lo count", irq_lo_n - b_lo, 1);
    chk("R1 default irq_hi count", irq_hi_n - b_hi, 1);

    // R11 mode change clears both halves
    mode = 2'd1;
    repeat (3) @(negedge clk);
    cap(1'b0); cap(1'b1);
    chk("R11 low cleared on mode change", int'(cap_lo), 0);
    chk("R11 high cleared on mode change", int'(cap_hi), 0);

    // R13 prescale write restarts prescaler
    do_reset(2'd0);
    wr(0, 5);
    run(1);
    wr(0, 0);
    run(3);
    cap(1'b0);
    chk("R13 prescaler restart on write", int'(cap_lo), 3);

    // Mode 0 sweep: R2 R3 R4 R8 R10
    foreach (p_set[i]) begin
      foreach (ml_set[j]) begin
        do_reset(2'd0);
        wr(0, p_set[i]); wr(1, ml_set[j]); wr(2, 3);
        b_lo = irq_lo_n; b_hi = irq_hi_n;
        run(37);
        cap(1'b0);
        chk("R2 R8 mid-run low capture", int'(cap_lo), (37 / (p_set[i] + 1)) % (ml_set[j] + 1));
        run(23);
        t = 60 / (p_set[i] + 1);
        cap(1'b0); cap(1'b1);
        chk("R10 R3 low count after capture", int'(cap_lo), t % (ml_set[j] + 1));
        chk("R4 high count", int'(cap_hi), t % 4);
        chk("R3 irq_lo pulses", irq_lo_n - b_lo, t / (ml_set[j] + 1));
        chk("R4 irq_hi pulses", irq_hi_n - b_hi, t / 4);
      end
    end

    // Mode 1: R5 R12
    for (int mh = 2; mh <= 3; mh++) begin
      for (int p = 0; p <= 2; p += 2) begin
        do_reset(2'd1);
        wr(0, p); wr(1, 4); wr(2, mh);
        b_lo = irq_lo_n; b_hi = irq_hi_n;
        run(30);
        evts(7);
        t = 30 / (p + 1);
        cap(1'b0); cap(1'b1);
        chk("R3 mode1 low timer", int'(cap_lo), t % 5);
        chk("R5 mode1 event count", int'(cap_hi), 7 % (mh + 1));
        chk("R3 mode1 irq_lo pulses", irq_lo_n - b_lo, t / 5);
        chk("R5 mode1 irq_hi pulses", irq_hi_n - b_hi, 7 / (mh + 1));
        long_evt();
        cap(1'b1);
        chk("R12 long pulse counts once", int'(cap_hi), 8 % (mh + 1));
      end
    end

    // Mode 2: R6 R9
    for (int c = 0; c < 2; c++) begin
      int p;
      p   = c;
      m16 = (c == 0) ? 16'h0010 : 16'h0104;
      k   = (c == 0) ? 100 : 1100;
      do_reset(2'd2);
      wr(0, p); wr(1, m16 & 255); wr(2, m16 >> 8);
      b_lo = irq_lo_n; b_hi = irq_hi_n;
      run(k);
      cap(1'b0);
      chk("R9 low strobe ignored cap_lo", int'(cap_lo), 0);
      chk("R9 low strobe ignored cap_hi", int'(cap_hi), 0);
      cap(1'b1);
      t = k / (p + 1);
      chk("R6 R9 16-bit capture", int'({cap_hi, cap_lo}), t % (m16 + 1));
      chk("R6 irq_hi pulses", irq_hi_n - b_hi, t / (m16 + 1));
      chk("R6 irq_lo silent", irq_lo_n - b_lo, 0);
    end

    // Mode 3: R7 R12
    do_reset(2'd3);
    wr(1, 3); wr(2, 0);
    b_lo = irq_lo_n; b_hi = irq_hi_n;
    run(40);
    evts(10);
    long_evt();
    cap(1'b1);
    chk("R7 R12 16-bit event count", int'({cap_hi, cap_lo}), 11 % 4);
    chk("R7 irq_hi pulses", irq_hi_n - b_hi, 11 / 4);
    chk("R7 irq_lo silent", irq_lo_n - b_lo, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule